// File: doc/BRIEF.md
# Acknowledge-Polling Write Completion Sequencer

This block sits on the master side of a two-wire serial bus, above a byte-level bus engine. It is used after the master has sent a write to a serial memory. The memory then runs an internal write cycle of unknown length. Rather than wait out a fixed worst-case delay, the sequencer keeps probing the target. Each probe is a Start condition followed by the target's control byte with the read/write bit cleared. A busy target does not acknowledge that byte. The first acknowledge shows that the write has finished.

User logic starts a poll run with a one-cycle request. The device code, the chip-select bits, the attempt limit and the finish mode are captured at that moment. The sequencer talks to the byte engine through a valid/ready command port and a response strobe. The response strobe carries the acknowledge result for byte commands.

When the target acknowledges, the run ends in one of two ways, chosen by the captured finish mode. In one mode the sequencer issues a Stop. In the other it leaves the bus held so that the next transfer can follow without a Stop. If the attempt limit runs out first, the sequencer releases the bus with a Stop, flags an error and goes back to idle.

Top module: `ackpoll_seq`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_valid_o`, `done_o` and `err_o` are low until a request arrives.
- R2: Each poll issues a START command (`cmd_o`=1) and then a BYTE command (`cmd_o`=2). The BYTE command carries the control byte: bits 7:4 hold the device code, bits 3:1 hold the chip-select bits and bit 0 is 0 (write direction).
- R3: When the response to a control byte has `rsp_ack_i` low, the next command is another START. No STOP (`cmd_o`=3) is placed between polls.
- R4: When the control byte is acknowledged and the captured `chain_i` is 0, one STOP follows and `done_o` is raised after its response. With `chain_i` set to 1, `done_o` is raised with no STOP issued.
- R5: `done_o` is high for exactly one clock per successful request.
- R6: After `max_polls_i` unacknowledged control bytes, one STOP is issued, `err_o` pulses for one clock and `done_o` stays low. A limit of 0 allows a single attempt. If the acknowledge arrives on the last allowed attempt, the run succeeds.
- R7: A command stays valid and unchanged until `cmd_ready_i` accepts it. Each command is issued once, and no new command is presented until the response strobe for the previous one has arrived.
- R8: A request that arrives during a run is ignored. Changes to the configuration inputs during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a poll run (accepted only in idle) |
| chain_i | input | 1 | 1: skip the Stop after the acknowledge |
| dev_code_i | input | 4 | Device code for control byte bits 7:4 |
| chip_sel_i | input | 3 | Chip-select bits for control byte bits 3:1 |
| max_polls_i | input | 8 | Attempt limit (0 is treated as 1) |
| done_o | output | 1 | One-cycle pulse: target acknowledged |
| err_o | output | 1 | One-cycle pulse: attempt limit exhausted |
| cmd_valid_o | output | 1 | Command valid to the byte engine |
| cmd_o | output | 2 | 1 START, 2 BYTE, 3 STOP, 0 none |
| cmd_data_o | output | 8 | Byte for BYTE commands, otherwise 0 |
| cmd_ready_i | input | 1 | Byte engine accepts the command |
| rsp_valid_i | input | 1 | Byte engine finished the last command |
| rsp_ack_i | input | 1 | Acknowledge result of a BYTE command |

## Verification
The bench drives a target model that refuses a chosen number of control bytes. It checks runs where the acknowledge comes on the first try, on the very last allowed try, and one try too late. An off-by-one in the limit logic would either give up on a target that was about to answer or send one probe too many. A limit of zero is also covered, where a design treating zero as unlimited would never stop.

Both finish modes are run, so a sequencer that always or never sends a Stop is caught. A stalled ready line checks that a design which drops or repeats a command under backpressure is caught. Extra requests and chip-select changes in the middle of a run would show up as a second run or as control bytes with the wrong value.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_BYTE  = 2'd2,
    CMD_STOP  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START_REQ,
    S_START_WAIT,
    S_CTRL_REQ,
    S_CTRL_WAIT,
    S_STOP_REQ,
    S_STOP_WAIT
  } seq_state_e;

endpackage

// File: rtl/ackpoll_ctrl_byte.sv
module ackpoll_ctrl_byte #(
  parameter int DEV_W = 4,
  parameter int SEL_W = 3,
  localparam int BYTE_W = DEV_W + SEL_W + 1
) (
  input  logic [DEV_W-1:0]  dev_code_i,
  input  logic [SEL_W-1:0]  chip_sel_i,
  output logic [BYTE_W-1:0] ctrl_byte_o
);
  // lsb is the direction bit: 0 = write
  assign ctrl_byte_o = {dev_code_i, chip_sel_i, 1'b0};
endmodule

// File: rtl/ackpoll_cfg_latch.sv
module ackpoll_cfg_latch #(
  parameter int DEV_W = 4,
  parameter int SEL_W = 3,
  parameter int CNT_W = 8,
  localparam int BYTE_W = DEV_W + SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DEV_W-1:0]  dev_code_i,
  input  logic [SEL_W-1:0]  chip_sel_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              chain_i,
  output logic [BYTE_W-1:0] ctrl_byte_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              chain_o
);
  logic [BYTE_W-1:0] byte_d;

  ackpoll_ctrl_byte #(.DEV_W(DEV_W), .SEL_W(SEL_W)) u_byte (
    .dev_code_i (dev_code_i),
    .chip_sel_i (chip_sel_i),
    .ctrl_byte_o(byte_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_byte_o <= '0;
      limit_o     <= '0;
      chain_o     <= 1'b0;
    end else if (load_i) begin
      ctrl_byte_o <= byte_d;
      limit_o     <= limit_i;
      chain_o     <= chain_i;
    end
  end
endmodule

// File: rtl/ackpoll_poll_cnt.sv
module ackpoll_poll_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W:0] cnt_q;
  logic [CNT_W:0] used;
  logic [CNT_W:0] eff_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // attempt currently in flight is number cnt_q+1; a zero limit means one try
  assign used      = cnt_q + 1'b1;
  assign eff_limit = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
  assign last_o    = (used >= eff_limit);
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int SEL_W = 3,
  parameter int CNT_W = 8,
  localparam int BYTE_W = DEV_W + SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              chain_i,
  input  logic [DEV_W-1:0]  dev_code_i,
  input  logic [SEL_W-1:0]  chip_sel_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              done_o,
  output logic              err_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  input  logic              cmd_ready_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i
);
  seq_state_e state_q, state_d;
  bus_cmd_e   cmd_e;
  logic       accept;
  logic       fail_q, fail_d;
  logic       done_d, err_d;
  logic       nack_seen;
  logic       last_try;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [CNT_W-1:0]  limit;
  logic              chain;

  assign accept = (state_q == S_IDLE) && req_i;

  ackpoll_cfg_latch #(.DEV_W(DEV_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .dev_code_i (dev_code_i),
    .chip_sel_i (chip_sel_i),
    .limit_i    (max_polls_i),
    .chain_i    (chain_i),
    .ctrl_byte_o(ctrl_byte),
    .limit_o    (limit),
    .chain_o    (chain)
  );

  assign nack_seen = (state_q == S_CTRL_WAIT) && rsp_valid_i && !rsp_ack_i;

  ackpoll_poll_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (nack_seen),
    .limit_i(limit),
    .last_o (last_try)
  );

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE:       if (req_i) begin
                      state_d = S_START_REQ;
                      fail_d  = 1'b0;
                    end
      S_START_REQ:  if (cmd_ready_i) state_d = S_START_WAIT;
      S_START_WAIT: if (rsp_valid_i) state_d = S_CTRL_REQ;
      S_CTRL_REQ:   if (cmd_ready_i) state_d = S_CTRL_WAIT;
      S_CTRL_WAIT:  if (rsp_valid_i) begin
                      if (rsp_ack_i) begin
                        if (chain) begin
                          state_d = S_IDLE;
                          done_d  = 1'b1;
                        end else begin
                          state_d = S_STOP_REQ;
                          fail_d  = 1'b0;
                        end
                      end else if (last_try) begin
                        state_d = S_STOP_REQ;
                        fail_d  = 1'b1;
                      end else begin
                        state_d = S_START_REQ;  // repeated start, no stop
                      end
                    end
      S_STOP_REQ:   if (cmd_ready_i) state_d = S_STOP_WAIT;
      S_STOP_WAIT:  if (rsp_valid_i) begin
                      state_d = S_IDLE;
                      done_d  = !fail_q;
                      err_d   = fail_q;
                    end
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fail_q  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_START_REQ: cmd_e = CMD_START;
      S_CTRL_REQ:  cmd_e = CMD_BYTE;
      S_STOP_REQ:  cmd_e = CMD_STOP;
      default:     cmd_e = CMD_NONE;
    endcase
  end

  assign cmd_valid_o = (cmd_e != CMD_NONE);
  assign cmd_o       = cmd_e;
  assign cmd_data_o  = (state_q == S_CTRL_REQ) ? ctrl_byte : '0;
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              err_o,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_o,
  input logic [BYTE_W-1:0] cmd_data_o,
  input logic              cmd_ready_i,
  input logic              rsp_valid_i
);
  logic outstanding_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         outstanding_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i) outstanding_q <= 1'b1;
    else if (rsp_valid_i)                outstanding_q <= 1'b0;
  end

  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_data_o));

  p_no_cmd_outstanding_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_q |-> !cmd_valid_o);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_done_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_write_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_o == 2'd2 |-> cmd_data_o[0] == 1'b0);

  p_end_after_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> $past(rsp_valid_i));
endmodule

bind ackpoll_seq ackpoll_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .err_o      (err_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_o      (cmd_o),
  .cmd_data_o (cmd_data_o),
  .cmd_ready_i(cmd_ready_i),
  .rsp_valid_i(rsp_valid_i)
);

// File: tb/ackpoll_seq_test.sv
module ackpoll_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       chain_i = 1'b0;
  logic [3:0] dev_code_i = 4'hA;
  logic [2:0] chip_sel_i = 3'd0;
  logic [7:0] max_polls_i = 8'd10;
  logic       done_o, err_o, cmd_valid_o;
  logic [1:0] cmd_o;
  logic [7:0] cmd_data_o;
  logic       cmd_ready_i = 1'b1;
  logic       rsp_valid_i = 1'b0;
  logic       rsp_ack_i = 1'b0;

  int n_tests = 0, n_fail = 0;
  int busy_left = 0, stall_left = 0;
  int starts, bytes, stops, dones, errs, wide, bad_bytes, seq_bad;
  logic [1:0] prev_cmd;
  logic [7:0] exp_byte;
  logic pending = 1'b0, pend_ack = 1'b0, prev_done = 1'b0, prev_err = 1'b0;

  ackpoll_seq uut (.*);

  always #4 clk_i = ~clk_i;

  // target + byte engine model, acting on falling edges
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) dones++;
      if (err_o) errs++;
      if ((done_o && prev_done) || (err_o && prev_err)) wide++;
      prev_done = done_o;
      prev_err  = err_o;
      rsp_valid_i = 1'b0;
      if (pending) begin
        rsp_valid_i = 1'b1;
        rsp_ack_i   = pend_ack;
        pending     = 1'b0;
      end else begin
        cmd_ready_i = (stall_left == 0);
        if (stall_left > 0) stall_left--;
        if (cmd_valid_o && cmd_ready_i) begin
          case (cmd_o)
            2'd1: begin
              starts++;
              if (prev_cmd == 2'd1 || prev_cmd == 2'd3) seq_bad++;
              pend_ack = 1'b1;
            end
            2'd2: begin
              bytes++;
              if (prev_cmd != 2'd1) seq_bad++;
              if (cmd_data_o != exp_byte) bad_bytes++;
              pend_ack = (busy_left == 0);
              if (busy_left > 0) busy_left--;
            end
            2'd3: begin
              stops++;
              if (prev_cmd == 2'd3) seq_bad++;
              pend_ack = 1'b1;
            end
            default: seq_bad++;
          endcase
          prev_cmd = cmd_o;
          pending  = 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    starts = 0; bytes = 0; stops = 0; dones = 0; errs = 0;
    wide = 0; bad_bytes = 0; seq_bad = 0; prev_cmd = 2'd0;
  endtask

  // one poll run; disturb pulses a second request and changes chip-select mid-run
  task automatic run(input int busy, input int lim, input bit chain, input logic [3:0] dev,
                     input logic [2:0] cs, input int stall, input bit disturb, input string tag);
    int eff, exp_polls, exp_stops;
    bit ok;
    eff = (lim == 0) ? 1 : lim;
    ok  = (busy + 1) <= eff;
    exp_polls = ok ? busy + 1 : eff;
    exp_stops = (ok && chain) ? 0 : 1;
    @(negedge clk_i);
    clear_counts();
    busy_left  = busy;
    stall_left = stall;
    dev_code_i = dev; chip_sel_i = cs; max_polls_i = lim[7:0]; chain_i = chain;
    exp_byte = {dev, cs, 1'b0};
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk_i);
      req_i = 1'b1; chip_sel_i = ~cs; dev_code_i = ~dev; chain_i = ~chain;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    for (int i = 0; i < 3000 && dones == 0 && errs == 0; i++) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
    check(starts == exp_polls, {tag, " R3 start count"}, starts, exp_polls);
    check(bytes == exp_polls, {tag, " R2 control byte count"}, bytes, exp_polls);
    check(stops == exp_stops, {tag, " R4/R6 stop count"}, stops, exp_stops);
    check(dones == (ok ? 1 : 0), {tag, " R5 done pulses"}, dones, ok ? 1 : 0);
    check(errs == (ok ? 0 : 1), {tag, " R6 err pulses"}, errs, ok ? 0 : 1);
    check(wide == 0, {tag, " R5 pulse width"}, wide, 0);
    check(bad_bytes == 0, {tag, " R2/R8 control byte value"}, bad_bytes, 0);
    check(seq_bad == 0, {tag, " R3/R7 command order"}, seq_bad, 0);
    check(cmd_valid_o == 1'b0, {tag, " R8 idle after run"}, cmd_valid_o, 0);
    chip_sel_i = cs; dev_code_i = dev;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(cmd_valid_o == 1'b0, "R1 valid in reset", cmd_valid_o, 0);
    check(done_o == 1'b0 && err_o == 1'b0, "R1 done/err in reset", {done_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(cmd_valid_o == 1'b0, "R1 valid after reset", cmd_valid_o, 0);
    check(done_o == 1'b0 && err_o == 1'b0, "R1 done/err after reset", {done_o, err_o}, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run(0, 10, 1'b0, 4'hA, 3'd0, 0, 1'b0, "R4 immediate ack stop");
    run(3, 10, 1'b1, 4'hA, 3'd5, 0, 1'b0, "R3 busy chained");
    run(5, 10, 1'b0, 4'h5, 3'd2, 0, 1'b0, "R3 busy with stop");
    run(3, 3, 1'b0, 4'hA, 3'd1, 0, 1'b0, "R6 limit exhausted");
    run(3, 4, 1'b1, 4'hA, 3'd1, 0, 1'b0, "R6 last attempt ok");
    run(2, 0, 1'b0, 4'hC, 3'd7, 0, 1'b0, "R6 zero limit");
    run(0, 0, 1'b1, 4'hC, 3'd7, 0, 1'b0, "R6 zero limit ack");
    run(2, 10, 1'b0, 4'h3, 3'd4, 7, 1'b0, "R7 backpressure");
    run(4, 10, 1'b0, 4'h9, 3'd6, 0, 1'b1, "R8 ignore mid-run");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule